// File: doc/BRIEF.md
# Piecewise-Linear Gamma Correction Unit

This block applies a 16-segment piecewise-linear transfer curve to every colour component of a streamed pixel with 12 bits per component. Red, green and blue each have their own curve, and an alpha curve exists when the alpha parameter is set. Software loads the curves through a word-addressed write port, which can also be read back. Each curve point stores a segment start X, an offset C in unsigned 12.4 format and a gradient in unsigned 4.8 format. For each component the block picks the segment the input falls into. It multiplies the gradient by the distance from that segment's start, adds the offset, then rounds and saturates the result to 12 bits.

Pixels move through a two-stage valid/ready pipeline. The first stage runs the segment search. The second stage does the multiply-add and holds the output register. The curve parameters for a pixel are captured in the cycle it is accepted, so a register write never corrupts a pixel already in flight. A per-pixel enable input skips the curve and passes the pixel through unchanged. When the alpha parameter is cleared, the alpha component always passes through unchanged, and words addressed to the alpha curve are dropped.

Top module: `gamma_pwl`

## Requirements
- R1: After reset every curve holds the identity: point i has X = 256·i, C = 4096·i (12.4 format) and gradient 256 (1.0 in 4.8). With the curve enabled, every component comes out equal to its input.
- R2: Word address = component·32 + point·2 + word select. Components are ordered red 0, green 1, blue 2, alpha 3. Word 0 carries X in bits [31:20] and C in bits [15:0]. Word 1 carries the gradient in bits [11:0]. Reads return those fields with all other bits zero, and written bits outside the fields are dropped.
- R3: The selected segment is the highest-indexed point whose X is less than or equal to the input. If no point qualifies, point 0 is used with a distance of 0.
- R4: The result is y = (C + floor(G·(in − X)/16) + 8) >> 4. That is, the 16.8 product is aligned to 12.4, added to C, and rounded half-up to 12 bits.
- R5: Any result above 4095 is clamped to 4095.
- R6: A pixel accepted while gamma_en is 0 leaves the block unchanged in all components.
- R7: Pixel component k sits in bits [12k+11:12k]. Alpha (k = 3) is shaped by its own curve, independently of the colour curves.
- R8: A pixel accepted at clock edge k appears on the output after edge k+1 when the output is not stalled. The pipeline sustains one pixel per cycle.
- R9: While out_valid is high and out_ready low, out_pix holds steady. in_ready drops once both stages are full, and no pixel is lost or duplicated.
- R10: Curve parameters are captured when a pixel is accepted. A write that lands after acceptance affects only pixels accepted later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Curve word write strobe |
| cfg_addr | input | $clog2(NPTS)+3 | Word address for reads and writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| gamma_en | input | 1 | Apply the curves to the pixel being accepted |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel can be accepted |
| in_pix | input | 48 | Input pixel, four 12-bit components |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | 48 | Corrected pixel |

## Verification
The assertions check the following on every cycle:
- the stall-hold and backpressure rules of the handshake;
- that no point above the chosen segment starts at or below the input;
- that a bypassed pixel leaves stage one unaltered;
- that an accepted pixel fills stage one;
- that stalled captured parameters stay put;
- that a written word lands in the addressed point.

The arithmetic can only be shown by the bench's scenarios, where a behavioural model predicts every output pixel. These scenarios cover rounding, saturation, the below-first-point case, the alpha curve, readback masking, latency, and the isolation of in-flight pixels from writes.

// File: rtl/gamma_pwl_pkg.sv
package gamma_pwl_pkg;
  localparam int unsigned PIX_W   = 12;
  localparam int unsigned NCOMP_MAX = 4;
  localparam int unsigned X_W     = 12;
  localparam int unsigned C_W     = 16;
  localparam int unsigned G_W     = 12;
  localparam int unsigned PROD_W  = G_W + PIX_W;
  localparam int unsigned ACC_W   = PROD_W - 4 + 1;
  localparam int unsigned FULL    = 1 << PIX_W;
  localparam int unsigned G_ONE   = 256;

  typedef struct packed {
    logic [X_W-1:0] x;
    logic [C_W-1:0] c;
    logic [G_W-1:0] g;
  } point_t;

  typedef struct packed {
    logic [C_W-1:0]   c;
    logic [G_W-1:0]   g;
    logic [PIX_W-1:0] d;
  } seg_t;

  function automatic point_t ident_pt(int unsigned p, int unsigned n);
    point_t r;
    int unsigned xs;
    xs  = p * (FULL / n);
    r.x = X_W'(xs);
    r.c = C_W'(xs * 16);
    r.g = G_W'(G_ONE);
    return r;
  endfunction
endpackage

// File: rtl/gamma_pwl_bank.sv
module gamma_pwl_bank
  import gamma_pwl_pkg::*;
#(
  parameter int unsigned NPTS  = 16,
  parameter int unsigned NCOMP = 4,
  parameter int unsigned PT_W  = $clog2(NPTS),
  parameter int unsigned AW    = PT_W + 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [AW-1:0]                  addr,
  input  logic [31:0]                    wdata,
  output logic [31:0]                    rdata,
  output point_t [NCOMP-1:0][NPTS-1:0]   pts_o
);
  logic [1:0]      a_comp;
  logic [PT_W-1:0] a_pt;
  logic            a_sel;

  assign a_comp = addr[AW-1 -: 2];
  assign a_pt   = addr[PT_W:1];
  assign a_sel  = addr[0];

  for (genvar gc = 0; gc < NCOMP; gc++) begin : g_comp
    for (genvar gp = 0; gp < NPTS; gp++) begin : g_pt
      point_t pt_q, pt_d;
      logic   hit;
      assign hit = we && (a_comp == 2'(gc)) && (a_pt == PT_W'(gp));

      always_comb begin
        pt_d = pt_q;
        if (hit && !a_sel) begin
          pt_d.x = wdata[31:20];
          pt_d.c = wdata[15:0];
        end
        if (hit && a_sel) begin
          pt_d.g = wdata[G_W-1:0];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pt_q <= ident_pt(gp, NPTS);
        end else if (hit) begin
          pt_q <= pt_d;
        end
      end

      assign pts_o[gc][gp] = pt_q;
    end
  end

  always_comb begin
    point_t rp;
    rdata = '0;
    rp    = '0;
    if (32'(a_comp) < NCOMP) begin
      rp = pts_o[a_comp][a_pt];
      if (a_sel) begin
        rdata[G_W-1:0] = rp.g;
      end else begin
        rdata[31:20] = rp.x;
        rdata[15:0]  = rp.c;
      end
    end
  end

  // R2
  wr_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !a_sel && 32'(a_comp) < NCOMP)
      |=> (pts_o[$past(a_comp)][$past(a_pt)].x == $past(wdata[31:20])));

  // R2
  wr_g_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && a_sel && 32'(a_comp) < NCOMP)
      |=> (pts_o[$past(a_comp)][$past(a_pt)].g == $past(wdata[G_W-1:0])));
endmodule

// File: rtl/gamma_pwl_seg.sv
module gamma_pwl_seg
  import gamma_pwl_pkg::*;
#(
  parameter int unsigned NPTS = 16,
  parameter int unsigned IW   = $clog2(NPTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  point_t [NPTS-1:0]      pts,
  input  logic [PIX_W-1:0]       pix,
  output seg_t                   seg
);
  logic [IW-1:0] idx;
  point_t        sel;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NPTS; i++) begin
      if (pts[i].x <= pix) idx = IW'(i);
    end
  end

  assign sel   = pts[idx];
  assign seg.c = sel.c;
  assign seg.g = sel.g;
  assign seg.d = (pix >= sel.x) ? (pix - sel.x) : '0;

  for (genvar gj = 0; gj < NPTS; gj++) begin : g_chk
    // R3
    above_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (IW'(gj) > idx) |-> (pts[gj].x > pix));
  end

  // R3
  below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.x > pix) |-> (idx == '0 && seg.d == '0));
endmodule

// File: rtl/gamma_pwl_eval.sv
module gamma_pwl_eval
  import gamma_pwl_pkg::*;
(
  input  seg_t              seg,
  input  logic              byp,
  input  logic [PIX_W-1:0]  raw,
  output logic [PIX_W-1:0]  y
);
  logic [PROD_W-1:0]    prod;
  logic [ACC_W-1:0]     acc;
  logic [ACC_W-1:0]     rnd;
  logic [ACC_W-5:0]     yw;
  logic [PIX_W-1:0]     ysat;

  assign prod = PROD_W'(seg.g) * PROD_W'(seg.d);
  assign acc  = ACC_W'(seg.c) + ACC_W'(prod[PROD_W-1:4]);
  assign rnd  = acc + ACC_W'(8);
  assign yw   = rnd[ACC_W-1:4];
  assign ysat = (|yw[ACC_W-5:PIX_W]) ? {PIX_W{1'b1}} : yw[PIX_W-1:0];
  assign y    = byp ? raw : ysat;
endmodule

// File: rtl/gamma_pwl.sv
module gamma_pwl
  import gamma_pwl_pkg::*;
#(
  parameter int unsigned NPTS     = 16,
  parameter bit          ALPHA_EN = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [$clog2(NPTS)+2:0]      cfg_addr,
  input  logic [31:0]                  cfg_wdata,
  output logic [31:0]                  cfg_rdata,
  input  logic                         gamma_en,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [4*12-1:0]              in_pix,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [4*12-1:0]              out_pix
);
  localparam int unsigned NCOMP = ALPHA_EN ? 4 : 3;
  localparam int unsigned PT_W  = $clog2(NPTS);
  localparam int unsigned AW    = PT_W + 3;
  localparam int unsigned PW    = NCOMP_MAX * PIX_W;

  point_t [NCOMP-1:0][NPTS-1:0] pts;
  seg_t   [NCOMP-1:0]           seg_in;
  logic   [PW-1:0]              y_all;

  // stage one state
  logic                s1_v, s1_v_d;
  logic                s1_byp;
  logic [PW-1:0]       s1_pix;
  seg_t [NCOMP-1:0]    s1_seg;
  // output stage state
  logic                ov_q, ov_d;
  logic [PW-1:0]       opix_q;

  logic                acc_in;
  logic                load_o;

  gamma_pwl_bank #(.NPTS(NPTS), .NCOMP(NCOMP), .PT_W(PT_W), .AW(AW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .pts_o (pts)
  );

  for (genvar gk = 0; gk < NCOMP_MAX; gk++) begin : g_lane
    if (gk < NCOMP) begin : g_curve
      gamma_pwl_seg #(.NPTS(NPTS)) u_seg (
        .clk   (clk),
        .rst_n (rst_n),
        .pts   (pts[gk]),
        .pix   (in_pix[gk*PIX_W +: PIX_W]),
        .seg   (seg_in[gk])
      );
      gamma_pwl_eval u_eval (
        .seg   (s1_seg[gk]),
        .byp   (s1_byp),
        .raw   (s1_pix[gk*PIX_W +: PIX_W]),
        .y     (y_all[gk*PIX_W +: PIX_W])
      );
    end else begin : g_thru
      assign y_all[gk*PIX_W +: PIX_W] = s1_pix[gk*PIX_W +: PIX_W];
    end
  end

  // handshake next-state
  always_comb begin
    load_o   = s1_v && (!ov_q || out_ready);
    in_ready = !s1_v || load_o;
    acc_in   = in_valid && in_ready;

    s1_v_d = s1_v;
    if (acc_in)      s1_v_d = 1'b1;
    else if (load_o) s1_v_d = 1'b0;

    ov_d = ov_q;
    if (load_o)         ov_d = 1'b1;
    else if (out_ready) ov_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      ov_q <= 1'b0;
    end else begin
      s1_v <= s1_v_d;
      ov_q <= ov_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_byp <= 1'b0;
      s1_pix <= '0;
      s1_seg <= '0;
    end else if (acc_in) begin
      s1_byp <= !gamma_en;
      s1_pix <= in_pix;
      s1_seg <= seg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opix_q <= '0;
    end else if (load_o) begin
      opix_q <= y_all;
    end
  end

  assign out_valid = ov_q;
  assign out_pix   = opix_q;

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  // R9
  full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && out_valid && !out_ready) |-> !in_ready);

  // R6
  byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && s1_byp) |=> (out_pix == $past(s1_pix)));

  // R8
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> s1_v);

  // R10
  cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !load_o) |=> $stable(s1_seg));
endmodule

// File: tb/gamma_pwl_tb.sv
module gamma_pwl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [6:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        gamma_en;
  logic        in_valid;
  logic        in_ready;
  logic [47:0] in_pix;
  logic        out_valid;
  logic        out_ready;
  logic [47:0] out_pix;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  string cur_req = "R1";

  int mx [4][16];
  int mc [4][16];
  int mg [4][16];
  logic [47:0] q[$];

  bit         rnd_mode = 0;
  logic       rdy_force = 1'b1;
  logic [7:0] lfsr = 8'hA5;
  bit         prev_stall = 0;
  logic [47:0] prev_pix;

  always #5 clk = ~clk;

  gamma_pwl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .gamma_en(gamma_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 16; i++) begin
        mx[k][i] = i * 256;
        mc[k][i] = i * 4096;
        mg[k][i] = 256;
      end
  endtask

  function automatic int ref_comp(int k, int v);
    int idx, d, y;
    idx = 0;
    for (int i = 0; i < 16; i++) if (mx[k][i] <= v) idx = i;
    d = (v >= mx[k][idx]) ? v - mx[k][idx] : 0;
    y = (mc[k][idx] + (mg[k][idx] * d) / 16 + 8) / 16;
    if (y > 4095) y = 4095;
    return y;
  endfunction

  function automatic logic [47:0] ref_pix(logic [47:0] p, logic en);
    logic [47:0] r;
    r = p;
    if (en) for (int k = 0; k < 4; k++) r[k*12 +: 12] = 12'(ref_comp(k, int'(p[k*12 +: 12])));
    return r;
  endfunction

  function automatic logic [47:0] mk(int r, int g, int b, int a);
    return {12'(a), 12'(b), 12'(g), 12'(r)};
  endfunction

  // out_ready driver
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= rnd_mode ? (lfsr[0] | lfsr[2]) : rdy_force;
  end

  // cycle model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (prev_stall) chk(out_valid && out_pix == prev_pix, "R9 hold", out_pix, prev_pix);
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(0, {cur_req, " spurious"}, out_pix, 48'h0);
        else begin
          logic [47:0] e;
          e = q.pop_front();
          chk(out_pix == e, cur_req, out_pix, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_pix   = out_pix;
      if (in_valid && in_ready) q.push_back(ref_pix(in_pix, gamma_en));
      if (cfg_we) begin
        int k, p;
        k = int'(cfg_addr[6:5]);
        p = int'(cfg_addr[4:1]);
        if (!cfg_addr[0]) begin
          mx[k][p] = int'(cfg_wdata[31:20]);
          mc[k][p] = int'(cfg_wdata[15:0]);
        end else mg[k][p] = int'(cfg_wdata[11:0]);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    cfg_addr = 7'(a); cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] e, input string req);
    cfg_addr = 7'(a);
    @(negedge clk);
    chk(cfg_rdata == e, req, {16'h0, cfg_rdata}, {16'h0, e});
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [47:0] p, input logic en);
    in_pix = p; gamma_en = en; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    rnd_mode = 0; rdy_force = 1'b1;
    while (q.size() != 0 || out_valid) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    gamma_en = 1'b1; in_valid = 1'b0; in_pix = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // reset state
    @(negedge clk);
    chk(!out_valid && in_ready, "R8 reset", {46'h0, out_valid, in_ready}, 48'h1);
    @(posedge clk); #1;
    cur_req = "R1";
    rd_chk(42, 32'h5000_5000, "R1 ident word0");
    rd_chk(43, 32'h0000_0100, "R1 ident word1");
    rd_chk(127, 32'h0000_0100, "R1 alpha last point");

    // identity curve
    send(mk(0, 1, 2, 3), 1);
    send(mk(4095, 2048, 255, 256), 1);
    send(mk(1234, 3333, 777, 4000), 1);
    drain();

    // latency
    cur_req = "R8";
    send(mk(10, 20, 30, 40), 1);
    @(negedge clk);
    chk(!out_valid, "R8 not yet", {47'h0, out_valid}, 48'h0);
    @(negedge clk);
    chk(out_valid, "R8 arrives", {47'h0, out_valid}, 48'h1);
    @(posedge clk); #1;
    drain();

    // curve programming and readback
    wr(16, {12'd2048, 4'hF, 16'd48000});
    wr(17, 32'hFFFF_F800);
    rd_chk(16, 32'h8000_BB80, "R2 word0 mask");
    rd_chk(17, 32'h0000_0800, "R2 word1 mask");
    wr(38, {12'd768, 4'h0, 16'h0018});
    wr(39, 32'h0);
    wr(64, {12'd100, 4'h0, 16'd1600});
    wr(97, 32'h0000_0080);
    rd_chk(38, 32'h3000_0018, "R2 green point3");

    cur_req = "R4";
    send(mk(2100, 800, 150, 200), 1);
    send(mk(2047, 1023, 2000, 1), 1);
    drain();
    cur_req = "R3";
    send(mk(2304, 770, 50, 0), 1);
    send(mk(99, 767, 100, 255), 1);
    drain();
    cur_req = "R5";
    send(mk(2500, 4095, 4095, 4095), 1);
    send(mk(2300, 3000, 3000, 3000), 1);
    drain();
    cur_req = "R7";
    send(mk(0, 0, 0, 200), 1);
    send(mk(0, 0, 0, 4095), 1);
    drain();
    cur_req = "R6";
    send(mk(2500, 800, 50, 200), 0);
    send(mk(4095, 1, 2, 3), 0);
    drain();

    // random backpressure stream
    cur_req = "R9";
    rnd_mode = 1;
    for (int i = 0; i < 60; i++)
      send(mk((i * 331) % 4096, (i * 977) % 4096, (i * 53) % 4096, (i * 1409) % 4096), (i % 5) != 0);
    drain();

    // write while in flight
    cur_req = "R10";
    rdy_force = 1'b0;
    @(posedge clk); #1;
    send(mk(2100, 0, 0, 0), 1);
    send(mk(2200, 0, 0, 0), 1);
    wr(17, 32'h0000_0000);
    wr(16, {12'd2048, 4'h0, 16'd100});
    rdy_force = 1'b1;
    drain();
    send(mk(2100, 0, 0, 0), 1);
    drain();

    repeat (3) @(posedge clk);
    chk(q.size() == 0, "R9 no loss", 48'(q.size()), 48'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule